// File: doc/BRIEF.md
# Card Window Address Decoder

This block holds eight programmable address windows. Each window maps part of the host bus address space onto one of two card slots. Every window has two 32-bit registers: a base register and an option register. The option register carries the valid flag, the write-protect flag, the slot select, the access space, the port width, a five-bit size code and three access-timing counts.

Each host address is compared against every enabled window at the same time. When at least one window matches, the lowest-numbered one wins. The block then reports:
- the winning window's number, slot, space and port width;
- its setup, strobe and hold counts;
- the card-side address.

There is no offset register, so the card-side address is simply the host address's offset within the window. A write that lands in a write-protected window raises a protect error and is not forwarded to the card.

The size code is a scrambled encoding that covers sizes from one byte to 64 MB. Five of its values are reserved, and a window that carries one of them never matches.

Top module: `cwin_decoder`

## Requirements
- R1: Register address bits [3:1] select the window and bit [0] selects base (0) or option (1). A write is stored on the clock edge, and `cfg_rdata` shows the addressed register combinationally. Every register is zero after reset.
- R2: Option field positions are: bit 0 valid, bit 1 write protect, bit 2 slot (0 = slot A, 1 = slot B), bits [4:3] space, bit 6 16-bit port. These fields appear on `win_slot`, `win_space` and `win_wide` for the winning window.
- R3: Size codes 0..15 give these sizes in bytes, in code order: 1, 2, 8, 4, 128, 64, 16, 32, 32768, 16384, 4096, 8192, 256, 512, 2048, 1024.
- R4: Size codes 20, 21 and 23 give 16M, 32M and 64M bytes. Codes 24..31 give, in code order, 64K, 128K, 512K, 256K, 8M, 4M, 1M and 2M bytes. A window carrying code 16, 17, 18, 19 or 22 never hits.
- R5: A window hits when it is valid, `host_valid` is high, and `host_addr` equals its base in every bit above the window's size. With `host_valid` low, `win_hit` is 0.
- R6: Space codes are 2'b00 common memory, 2'b10 attribute memory and 2'b11 I/O. A window whose space is 2'b01 never hits.
- R7: When several windows hit, the lowest-numbered one is reported.
- R8: `t_setup`, `t_strobe` and `t_hold` take option bits [15:12], [11:7] and [19:16] of the winning window. With no hit, they and every other result output are 0.
- R9: A write (`host_write` high) that hits a write-protected window raises `prot_err` and holds `card_fwd` low. Any other hit drives `card_fwd` high.
- R10: Writing zero to an option register disables that window.
- R11: Address decode is combinational from the host inputs. A register write changes the mapping from the cycle after its clock edge.
- R12: `card_off` equals `host_addr` masked to the winning window's size, and is 0 with no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select: window and base/option |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Contents of the selected register |
| host_valid | input | 1 | Host access present |
| host_write | input | 1 | Host access is a write |
| host_addr | input | 32 | Host bus address |
| win_hit | output | 1 | Some window matches |
| win_idx | output | 3 | Winning window number |
| win_slot | output | 1 | Target slot of the winner |
| win_space | output | 2 | Access space of the winner |
| win_wide | output | 1 | 16-bit port flag of the winner |
| card_off | output | 32 | Card-side address (offset within the window) |
| prot_err | output | 1 | Write into a protected window |
| card_fwd | output | 1 | Access is passed to the card |
| t_setup | output | 4 | Setup cycle count |
| t_strobe | output | 5 | Strobe length cycle count |
| t_hold | output | 4 | Hold cycle count |

## Verification
Every decode result is due in the same cycle that the host inputs change. The bench drives the host inputs on the falling edge and samples all outputs one nanosecond later, well before the next rising edge. A register write lands on the rising edge that follows its falling-edge setup. Read-back values and probes of the new mapping are therefore taken only after the next falling edge, which is the first cycle in which the written value is due. Expected results come from a model in the bench that holds the register contents and its own byte-size list for each size code.

// File: rtl/cwin_pkg.sv
package cwin_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        SP_COMMON = 2'b00,
        SP_BAD    = 2'b01,
        SP_ATTR   = 2'b10,
        SP_IO     = 2'b11
    } space_e;

    typedef struct packed {
        logic [4:0] size_code;
        logic [3:0] hold;
        logic [3:0] setup;
        logic [4:0] strobe;
        logic       wide;
        space_e     space;
        logic       slot;
        logic       wprot;
        logic       valid;
    } win_cfg_t;

    function automatic win_cfg_t opt_to_cfg(input logic [REG_W-1:0] o);
        win_cfg_t c;
        c.size_code = o[31:27];
        c.hold      = o[19:16];
        c.setup     = o[15:12];
        c.strobe    = o[11:7];
        c.wide      = o[6];
        c.space     = space_e'(o[4:3]);
        c.slot      = o[2];
        c.wprot     = o[1];
        c.valid     = o[0];
        return c;
    endfunction

    // Codes 16..19 and 22 carry no size.
    function automatic logic size_code_ok(input logic [4:0] code);
        return !((code >= 5'd16 && code <= 5'd19) || code == 5'd22);
    endfunction

    // log2 of the window size in bytes for each size code
    function automatic logic [5:0] size_log2(input logic [4:0] code);
        case (code)
            5'd0:  return 6'd0;
            5'd1:  return 6'd1;
            5'd2:  return 6'd3;
            5'd3:  return 6'd2;
            5'd4:  return 6'd7;
            5'd5:  return 6'd6;
            5'd6:  return 6'd4;
            5'd7:  return 6'd5;
            5'd8:  return 6'd15;
            5'd9:  return 6'd14;
            5'd10: return 6'd12;
            5'd11: return 6'd13;
            5'd12: return 6'd8;
            5'd13: return 6'd9;
            5'd14: return 6'd11;
            5'd15: return 6'd10;
            5'd20: return 6'd24;
            5'd21: return 6'd25;
            5'd23: return 6'd26;
            5'd24: return 6'd16;
            5'd25: return 6'd17;
            5'd26: return 6'd19;
            5'd27: return 6'd18;
            5'd28: return 6'd23;
            5'd29: return 6'd22;
            5'd30: return 6'd20;
            5'd31: return 6'd21;
            default: return 6'd0;
        endcase
    endfunction

endpackage

// File: rtl/cwin_regs.sv
module cwin_regs
    import cwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int NREG = 2 * NWIN,
    localparam int RAW  = $clog2(NREG)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [RAW-1:0]              addr,
    input  logic [REG_W-1:0]            wdata,
    output logic [REG_W-1:0]            rdata,
    output logic [NWIN-1:0][REG_W-1:0]  base_q,
    output logic [NWIN-1:0][REG_W-1:0]  opt_q
);

    // Even entries are bases, odd entries are options.
    logic [NREG-1:0][REG_W-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    for (genvar w = 0; w < NWIN; w++) begin : g_split
        assign base_q[w] = mem[2*w];
        assign opt_q[w]  = mem[2*w+1];
    end

    AST_REG_STORE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(addr)] == $past(wdata)); // R1

endmodule

// File: rtl/cwin_match.sv
module cwin_match
    import cwin_pkg::*;
#(
    parameter int AW = REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    base,
    input  logic [REG_W-1:0] opt,
    input  logic [AW-1:0]    addr,
    output logic             match,
    output logic [AW-1:0]    low_mask
);

    win_cfg_t cfg;
    logic     usable;

    assign cfg      = opt_to_cfg(opt);
    assign low_mask = (AW'(1) << size_log2(cfg.size_code)) - AW'(1);
    assign usable   = cfg.valid && size_code_ok(cfg.size_code)
                      && (cfg.space != SP_BAD);
    assign match    = usable && ((addr & ~low_mask) == (base & ~low_mask));

    AST_RSV_MISS: assert property (@(posedge clk) disable iff (rst)
        (opt[31:27] inside {5'd16, 5'd17, 5'd18, 5'd19, 5'd22}) |-> !match); // R4

    AST_ZERO_OPT_MISS: assert property (@(posedge clk) disable iff (rst)
        (opt == '0) |-> !match); // R10

    AST_SPACE_BAD_MISS: assert property (@(posedge clk) disable iff (rst)
        (opt[4:3] == 2'b01) |-> !match); // R6

endmodule

// File: rtl/cwin_prio.sv
module cwin_prio
    import cwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int AW   = REG_W,
    localparam int IDXW = $clog2(NWIN)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NWIN-1:0]             match_vec,
    input  logic [NWIN-1:0][REG_W-1:0]  opt_q,
    input  logic [NWIN-1:0][AW-1:0]     mask_q,
    output logic                        hit,
    output logic [IDXW-1:0]             idx,
    output logic [REG_W-1:0]            sel_opt,
    output logic [AW-1:0]               sel_mask
);

    // Scan from the top down so the lowest matching window is assigned last.
    always_comb begin
        hit      = 1'b0;
        idx      = '0;
        sel_opt  = '0;
        sel_mask = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit      = 1'b1;
                idx      = IDXW'(i);
                sel_opt  = opt_q[i];
                sel_mask = mask_q[i];
            end
        end
    end

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
        hit |-> (match_vec[idx]
                 && ((match_vec & ((NWIN'(1) << idx) - NWIN'(1))) == '0))); // R7

    AST_HIT_MEANS_MATCH: assert property (@(posedge clk) disable iff (rst)
        hit == (match_vec != '0)); // R5

endmodule

// File: rtl/cwin_decoder.sv
module cwin_decoder
    import cwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int AW   = REG_W,
    localparam int IDXW = $clog2(NWIN),
    localparam int RAW  = $clog2(2 * NWIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [RAW-1:0]   cfg_addr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             host_valid,
    input  logic             host_write,
    input  logic [AW-1:0]    host_addr,
    output logic             win_hit,
    output logic [IDXW-1:0]  win_idx,
    output logic             win_slot,
    output logic [1:0]       win_space,
    output logic             win_wide,
    output logic [AW-1:0]    card_off,
    output logic             prot_err,
    output logic             card_fwd,
    output logic [3:0]       t_setup,
    output logic [4:0]       t_strobe,
    output logic [3:0]       t_hold
);

    logic [NWIN-1:0][REG_W-1:0] base_q;
    logic [NWIN-1:0][REG_W-1:0] opt_q;
    logic [NWIN-1:0][AW-1:0]    mask_q;
    logic [NWIN-1:0]            raw_match;
    logic [NWIN-1:0]            match_vec;
    logic                       hit;
    logic [IDXW-1:0]            idx;
    logic [REG_W-1:0]           sel_opt;
    logic [AW-1:0]              sel_mask;
    win_cfg_t                   sel_cfg;

    cwin_regs #(.NWIN(NWIN)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_wr),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .base_q (base_q),
        .opt_q  (opt_q)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        cwin_match #(.AW(AW)) u_match (
            .clk      (clk),
            .rst      (rst),
            .base     (base_q[w][AW-1:0]),
            .opt      (opt_q[w]),
            .addr     (host_addr),
            .match    (raw_match[w]),
            .low_mask (mask_q[w])
        );
    end

    assign match_vec = raw_match & {NWIN{host_valid}};

    cwin_prio #(.NWIN(NWIN), .AW(AW)) u_prio (
        .clk       (clk),
        .rst       (rst),
        .match_vec (match_vec),
        .opt_q     (opt_q),
        .mask_q    (mask_q),
        .hit       (hit),
        .idx       (idx),
        .sel_opt   (sel_opt),
        .sel_mask  (sel_mask)
    );

    assign sel_cfg = opt_to_cfg(sel_opt);

    always_comb begin
        win_hit   = hit;
        win_idx   = idx;
        win_slot  = hit & sel_cfg.slot;
        win_space = hit ? sel_cfg.space : 2'b00;
        win_wide  = hit & sel_cfg.wide;
        card_off  = hit ? (host_addr & sel_mask) : '0;
        t_setup   = hit ? sel_cfg.setup  : '0;
        t_strobe  = hit ? sel_cfg.strobe : '0;
        t_hold    = hit ? sel_cfg.hold   : '0;
        prot_err  = hit & host_write & sel_cfg.wprot;
        card_fwd  = hit & ~(host_write & sel_cfg.wprot);
    end

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !host_valid |-> !win_hit); // R5

    AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        prot_err |-> (!card_fwd && host_write && win_hit)); // R9

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !win_hit |-> (card_off == '0 && t_setup == '0 && t_strobe == '0
                      && t_hold == '0 && !card_fwd)); // R8

endmodule

// File: tb/cwin_decoder_bench.sv
module cwin_decoder_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [3:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        host_valid;
    logic        host_write;
    logic [31:0] host_addr;
    logic        win_hit;
    logic [2:0]  win_idx;
    logic        win_slot;
    logic [1:0]  win_space;
    logic        win_wide;
    logic [31:0] card_off;
    logic        prot_err;
    logic        card_fwd;
    logic [3:0]  t_setup;
    logic [4:0]  t_strobe;
    logic [3:0]  t_hold;

    int checks   = 0;
    int failures = 0;
    logic [31:0] mreg [16];

    always #2 clk = ~clk;

    cwin_decoder u_cwin_decoder (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
        .win_hit(win_hit), .win_idx(win_idx), .win_slot(win_slot),
        .win_space(win_space), .win_wide(win_wide), .card_off(card_off),
        .prot_err(prot_err), .card_fwd(card_fwd),
        .t_setup(t_setup), .t_strobe(t_strobe), .t_hold(t_hold)
    );

    // Window size in bytes per size code; 0 marks a reserved code.
    function automatic longint bytes_of(input int code);
        case (code)
            0: return 1;        1: return 2;        2: return 8;        3: return 4;
            4: return 128;      5: return 64;       6: return 16;       7: return 32;
            8: return 32768;    9: return 16384;    10: return 4096;    11: return 8192;
            12: return 256;     13: return 512;     14: return 2048;    15: return 1024;
            20: return 16777216; 21: return 33554432; 23: return 67108864;
            24: return 65536;   25: return 131072;  26: return 524288;  27: return 262144;
            28: return 8388608; 29: return 4194304; 30: return 1048576; 31: return 2097152;
            default: return 0;
        endcase
    endfunction

    task automatic fail_line(input string req, input string what,
                             input logic [127:0] act, input logic [127:0] exp);
        failures++;
        $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    endtask

    // Register write: set up on falling edge, stored on the next rising edge.
    task automatic reg_write(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        mreg[a] = d;
    endtask

    task automatic reg_check(input int a, input string req);
        @(negedge clk);
        cfg_addr = 4'(a);
        #1;
        checks++;
        if (cfg_rdata !== mreg[a]) fail_line(req, "rdata", 128'(cfg_rdata), 128'(mreg[a]));
    endtask

    // Compare every decode output against the bench model.
    task automatic probe(input logic v, input logic wr, input logic [31:0] a,
                         input string req);
        logic        e_hit = 0, e_slot = 0, e_wide = 0, e_perr = 0, e_fwd = 0;
        logic [2:0]  e_idx = 0;
        logic [1:0]  e_space = 0;
        logic [31:0] e_off = 0;
        logic [3:0]  e_setup = 0, e_hold = 0;
        logic [4:0]  e_strobe = 0;
        logic [63:0] exp_v, act_v;
        @(negedge clk);
        host_valid = v; host_write = wr; host_addr = a;
        #1;
        for (int w = 7; w >= 0; w--) begin
            logic [31:0] o = mreg[2*w+1];
            logic [31:0] b = mreg[2*w];
            longint sz = bytes_of(int'(o[31:27]));
            logic [31:0] m = 32'(sz - 1);
            if (v && o[0] && sz != 0 && o[4:3] != 2'b01 && ((a & ~m) == (b & ~m))) begin
                e_hit = 1; e_idx = 3'(w); e_slot = o[2]; e_space = o[4:3];
                e_wide = o[6]; e_off = a & m; e_setup = o[15:12];
                e_strobe = o[11:7]; e_hold = o[19:16];
                e_perr = wr & o[1]; e_fwd = !(wr & o[1]);
            end
        end
        exp_v = {e_hit, e_idx, e_slot, e_space, e_wide, e_perr, e_fwd,
                 e_setup, e_strobe, e_hold, e_off, 8'h0};
        act_v = {win_hit, win_idx, win_slot, win_space, win_wide, prot_err, card_fwd,
                 t_setup, t_strobe, t_hold, card_off, 8'h0};
        checks++;
        if (act_v !== exp_v) fail_line(req, "decode", 128'(act_v), 128'(exp_v));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fail_line("WATCHDOG", "timeout", 128'(0), 128'(1));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mreg[i] = '0;
        rst = 1'b1; cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0;
        host_valid = 0; host_write = 0; host_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state and read-back
        for (int i = 0; i < 16; i++) reg_check(i, "R1_reset");
        probe(1, 0, 32'h0000_0000, "R1_reset_nohit");
        for (int i = 0; i < 16; i++) reg_write(i, 32'hA5C3_0000 ^ (32'h0101_0107 * 32'(i)));
        for (int i = 0; i < 16; i++) reg_check(i, "R1_readback");
        for (int i = 0; i < 16; i++) reg_write(i, 32'h0);

        // R3 R4 R5 R12 size sweep on window 0
        reg_write(0, 32'h4000_0000);
        for (int c = 0; c < 32; c++) begin
            longint sz = bytes_of(c);
            logic [31:0] s32 = (sz == 0) ? 32'h1000 : 32'(sz);
            string tg = (c < 16) ? "R3_size" : "R4_size";
            reg_write(1, {5'(c), 27'h0} | 32'h1);
            probe(1, 0, 32'h4000_0000, tg);
            probe(1, 0, 32'h4000_0000 + s32 - 1, tg);
            probe(1, 0, 32'h4000_0000 + s32, tg);
            probe(1, 0, 32'h3FFF_FFFF, "R5_below");
        end
        reg_write(1, {5'd10, 27'h0} | 32'h1);
        probe(0, 0, 32'h4000_0123, "R5_idle");
        probe(1, 0, 32'h4000_0ABC, "R12_offset");

        // R2 R6 R8 field export, including space 2'b01
        for (int sp = 0; sp < 4; sp++) begin
            reg_write(1, {5'd10, 7'h0, 4'h9, 4'h3, 5'h15, 1'b1, 1'b0, 2'(sp), 1'b1, 1'b0, 1'b1});
            probe(1, 0, 32'h4000_0010, (sp == 1) ? "R6_space" : "R2_fields");
            probe(1, 0, 32'h4000_0FF0, "R8_timing");
        end
        reg_write(1, 32'h0);

        // R7 priority and R10 R11 disable effective the next cycle
        reg_write(4, 32'h1000_0000);
        reg_write(5, {5'd10, 7'h0, 4'h2, 4'h1, 5'h07, 1'b1, 1'b0, 2'b10, 1'b1, 1'b0, 1'b1});
        reg_write(10, 32'h1000_0000);
        reg_write(11, {5'd8, 7'h0, 4'h5, 4'h6, 5'h0C, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1});
        probe(1, 0, 32'h1000_0800, "R7_lowest");
        probe(1, 0, 32'h1000_2000, "R7_only_upper");
        reg_write(5, 32'h0);
        probe(1, 0, 32'h1000_0800, "R10_disabled");
        reg_write(5, {5'd10, 27'h1});
        probe(1, 0, 32'h1000_0800, "R11_new_map");

        // R9 write protect
        reg_write(6, 32'h2000_0000);
        reg_write(7, {5'd24, 7'h0, 4'h1, 4'h1, 5'h03, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1});
        probe(1, 1, 32'h2000_1234, "R9_prot_write");
        probe(1, 0, 32'h2000_1234, "R9_prot_read");
        probe(1, 1, 32'h1000_0004, "R9_plain_write");
        probe(1, 1, 32'h3000_0000, "R9_miss");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule